// File: doc/BRIEF.md
# Unaligned 256-bit Memory Align Unit

This unit sits between a byte-addressed access port and a memory organised as 256-bit words. A 32-byte access at byte address `a` generally straddles two words: the word at index `floor(a/32)` (called m0 here) and the one after it (m1). A separate block fetches those two words and supplies them with the byte offset `a mod 32`. This unit then does one of three jobs. It can pull the 32-byte value out of the pair. It can merge a 32-byte value into the pair. It can merge a single byte into the first word.

All byte numbering is big-endian. Byte 0 of a word is its most significant byte and byte 31 is its least significant byte. The pair m0, m1 is treated as one 64-byte stream, with m0 first.

Requests use a valid/ready handshake. The unit holds one request at a time. The result appears registered one cycle after acceptance and stays until the consumer takes it. Word address computation, memory fetch and write-back belong to other blocks.

Top module: `mem_align_unit`

## Requirements
- R1: Bytes are numbered big-endian: byte k of a 256-bit word occupies bits [(31-k)*8+7 : (31-k)*8]. A read (op 2'b00) returns, as byte i of `rsp_data`, byte `offset+i` of the 64-byte stream m0 followed by m1.
- R2: For a read, `rsp_w0` equals m0 and `rsp_w1` equals m1.
- R3: A read with offset 0 returns m0 exactly.
- R4: A 32-byte write (op 2'b01) places byte i of the value at stream byte `offset+i`; every other byte of m0 and m1 keeps its old contents; `rsp_data` is zero.
- R5: A 32-byte write with offset 0 gives `rsp_w0` equal to the value and `rsp_w1` equal to m1.
- R6: A 32-byte write with offset 31 changes only byte 31 of w0, to the value's most significant byte; w1 holds value bytes 1..31 in its bytes 0..30 and keeps byte 31 of m1.
- R7: A single-byte write (op 2'b10) stores only bits [7:0] of the value, at byte `offset` of w0; all other bytes of m0 are kept; `rsp_w1` equals m1; `rsp_data` is zero.
- R8: Op code 2'b11 is illegal: the response carries `rsp_err`=1, `rsp_data`=0, `rsp_w0`=m0 and `rsp_w1`=m1. Legal codes give `rsp_err`=0.
- R9: A request accepted on an edge (`req_valid` and `req_ready` high) produces `rsp_valid`=1 after that edge. `req_ready` stays low while a response is pending, and requests offered then are ignored.
- R10: While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold steady. An edge with both high clears `rsp_valid` and raises `req_ready`.
- R11: After synchronous active-low reset, `rsp_valid`=0, `req_ready`=1, and `rsp_data`, `rsp_w0`, `rsp_w1` and `rsp_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 2 | 00 read, 01 32-byte write, 10 byte write, 11 illegal |
| req_offset | input | 5 | Byte offset of the access within m0 |
| req_m0 | input | 256 | First word of the pair |
| req_m1 | input | 256 | Following word |
| req_val | input | 256 | Value to write (byte write uses bits [7:0]) |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 256 | Extracted read value, zero otherwise |
| rsp_w0 | output | 256 | Updated first word |
| rsp_w1 | output | 256 | Updated following word |
| rsp_err | output | 1 | Request carried the illegal op code |

## Verification
The assertions relate each response to the request fields sampled on the accepting edge through `$past`. They therefore assume the requester follows the handshake, so an accepted request is the one whose fields were on the ports at that edge. The stall properties assume that nothing but `rsp_ready` ends a pending response. The bench keeps to this by changing inputs only on falling edges. It offers a request only after it has seen `req_ready` high, and it raises `rsp_ready` only after its checks of the pending response are done. Deliberately ignored requests are offered only while a response is pending. Their only effect is checked through the steadiness of the response outputs.

// File: rtl/mau_pkg.sv
// Package: shared operation encoding for the memory align unit.
// Assumes: the op field is 2 bits wide on the request port.
package mau_pkg;
    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_WR32 = 2'b01,
        OP_WR8  = 2'b10,
        OP_BAD  = 2'b11
    } mau_op_e;
endpackage

// File: rtl/mau_read_extract.sv
// Module: mau_read_extract
// Pulls N consecutive bytes out of the 2N-byte big-endian stream {m0, m1},
// starting at byte 'off'. Purely combinational.
// Assumes: DATA_W is a multiple of 8 and DATA_W/8 is a power of two.
module mau_read_extract #(
    parameter int DATA_W = 256
) (
    input  logic [DATA_W-1:0]                 m0,
    input  logic [DATA_W-1:0]                 m1,
    input  logic [$clog2(DATA_W/8)-1:0]       off,
    output logic [DATA_W-1:0]                 rd_data
);
    localparam int N     = DATA_W / 8;
    localparam int OFF_W = $clog2(N);

    logic [7:0] cat_b [2*N];

    // Split the word pair into stream bytes, byte 0 = MSB of m0.
    for (genvar k = 0; k < N; k++) begin : g_split
        assign cat_b[k]     = m0[(N-1-k)*8 +: 8];
        assign cat_b[N + k] = m1[(N-1-k)*8 +: 8];
    end

    // Each output byte selects stream byte off+i.
    for (genvar i = 0; i < N; i++) begin : g_pick
        logic [OFF_W:0] idx;
        assign idx = {1'b0, off} + (OFF_W+1)'(i);
        assign rd_data[(N-1-i)*8 +: 8] = cat_b[idx];
    end
endmodule

// File: rtl/mau_write_merge.sv
// Module: mau_write_merge
// Builds the updated word pair for both write flavours: the full-width
// write spreading the value across the pair, and the one-byte write into m0.
// Purely combinational.
// Assumes: DATA_W is a multiple of 8 and DATA_W/8 is a power of two.
module mau_write_merge #(
    parameter int DATA_W = 256
) (
    input  logic [DATA_W-1:0]                 m0,
    input  logic [DATA_W-1:0]                 m1,
    input  logic [DATA_W-1:0]                 val,
    input  logic [$clog2(DATA_W/8)-1:0]       off,
    output logic [DATA_W-1:0]                 full_w0,
    output logic [DATA_W-1:0]                 full_w1,
    output logic [DATA_W-1:0]                 byte_w0
);
    localparam int N     = DATA_W / 8;
    localparam int OFF_W = $clog2(N);

    logic [7:0] val_b [N];

    // Value bytes in big-endian order.
    for (genvar k = 0; k < N; k++) begin : g_val
        assign val_b[k] = val[(N-1-k)*8 +: 8];
    end

    // Full-width write: stream byte j takes value byte j-off inside the window.
    for (genvar j = 0; j < 2*N; j++) begin : g_full
        localparam logic [OFF_W-1:0] JL = OFF_W'(j % N);
        logic [OFF_W-1:0] rel;
        logic             in_win;
        logic [7:0]       old_b;
        assign rel    = JL - off;
        assign in_win = (j >= int'(off)) && (j < int'(off) + N);
        if (j < N) begin : g_lo
            assign old_b = m0[(N-1-j)*8 +: 8];
            assign full_w0[(N-1-j)*8 +: 8] = in_win ? val_b[rel] : old_b;
        end else begin : g_hi
            assign old_b = m1[(2*N-1-j)*8 +: 8];
            assign full_w1[(2*N-1-j)*8 +: 8] = in_win ? val_b[rel] : old_b;
        end
    end

    // One-byte write: only byte 'off' of m0 takes the value's low byte.
    for (genvar j = 0; j < N; j++) begin : g_byte
        assign byte_w0[(N-1-j)*8 +: 8] =
            (off == OFF_W'(j)) ? val[7:0] : m0[(N-1-j)*8 +: 8];
    end
endmodule

// File: rtl/mau_resp_ctrl.sv
// Module: mau_resp_ctrl
// One-entry response register with valid/ready handshake on both sides.
// Loads the prepared result on acceptance and holds it until consumed.
// Assumes: synchronous active-low reset.
module mau_resp_ctrl #(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic [DATA_W-1:0] nxt_w0,
    input  logic [DATA_W-1:0] nxt_w1,
    input  logic              nxt_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [DATA_W-1:0] rsp_w0,
    output logic [DATA_W-1:0] rsp_w1,
    output logic              rsp_err
);
    logic accept;

    // Free to accept only when no response is pending.
    assign req_ready = !rsp_valid;
    assign accept    = req_valid && req_ready;

    // Capture the result on acceptance; drop valid once it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_w0    <= '0;
            rsp_w1    <= '0;
            rsp_err   <= 1'b0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_data  <= nxt_data;
            rsp_w0    <= nxt_w0;
            rsp_w1    <= nxt_w1;
            rsp_err   <= nxt_err;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/mem_align_unit.sv
// Module: mem_align_unit (top)
// Aligns a byte-offset 32-byte access onto a pair of consecutive words:
// read extraction, full-width write merge and single-byte write merge.
// The result is registered and offered one cycle after acceptance.
// Assumes: caller supplies the two words and the offset within the first.
module mem_align_unit
    import mau_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [1:0]                    req_op,
    input  logic [$clog2(DATA_W/8)-1:0]   req_offset,
    input  logic [DATA_W-1:0]             req_m0,
    input  logic [DATA_W-1:0]             req_m1,
    input  logic [DATA_W-1:0]             req_val,
    output logic                          rsp_valid,
    input  logic                          rsp_ready,
    output logic [DATA_W-1:0]             rsp_data,
    output logic [DATA_W-1:0]             rsp_w0,
    output logic [DATA_W-1:0]             rsp_w1,
    output logic                          rsp_err
);
    logic [DATA_W-1:0] rd_data, full_w0, full_w1, byte_w0;
    logic [DATA_W-1:0] nxt_data, nxt_w0, nxt_w1;
    logic              nxt_err;

    mau_read_extract #(.DATA_W(DATA_W)) rd_i (
        .m0      (req_m0),
        .m1      (req_m1),
        .off     (req_offset),
        .rd_data (rd_data)
    );

    mau_write_merge #(.DATA_W(DATA_W)) wr_i (
        .m0      (req_m0),
        .m1      (req_m1),
        .val     (req_val),
        .off     (req_offset),
        .full_w0 (full_w0),
        .full_w1 (full_w1),
        .byte_w0 (byte_w0)
    );

    // Choose the result set for the requested operation.
    always_comb begin
        nxt_data = '0;
        nxt_w0   = req_m0;
        nxt_w1   = req_m1;
        nxt_err  = 1'b0;
        case (mau_op_e'(req_op))
            OP_READ: nxt_data = rd_data;
            OP_WR32: begin
                nxt_w0 = full_w0;
                nxt_w1 = full_w1;
            end
            OP_WR8:  nxt_w0 = byte_w0;
            default: nxt_err = 1'b1;
        endcase
    end

    mau_resp_ctrl #(.DATA_W(DATA_W)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .nxt_data  (nxt_data),
        .nxt_w0    (nxt_w0),
        .nxt_w1    (nxt_w1),
        .nxt_err   (nxt_err),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .rsp_w0    (rsp_w0),
        .rsp_w1    (rsp_w1),
        .rsp_err   (rsp_err)
    );
endmodule

// File: rtl/mem_align_unit_chk.sv
// Module: mem_align_unit_chk
// Port-level properties of mem_align_unit, attached through bind below.
// Assumes: requester follows the valid/ready handshake.
module mem_align_unit_chk #(
    parameter int DATA_W = 256
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic [1:0]                    req_op,
    input logic [$clog2(DATA_W/8)-1:0]   req_offset,
    input logic [DATA_W-1:0]             req_m0,
    input logic [DATA_W-1:0]             req_m1,
    input logic [DATA_W-1:0]             req_val,
    input logic                          rsp_valid,
    input logic                          rsp_ready,
    input logic [DATA_W-1:0]             rsp_data,
    input logic [DATA_W-1:0]             rsp_w0,
    input logic [DATA_W-1:0]             rsp_w1,
    input logic                          rsp_err
);
    logic fire;
    assign fire = req_valid && req_ready;

    assert_read_keeps_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == 2'b00 |=> rsp_w0 == $past(req_m0) && rsp_w1 == $past(req_m1));

    assert_read_off0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == 2'b00 && req_offset == '0 |=> rsp_data == $past(req_m0));

    assert_write_off0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == 2'b01 && req_offset == '0 |=>
        rsp_w0 == $past(req_val) && rsp_w1 == $past(req_m1));

    assert_wr_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op != 2'b00 |=> rsp_data == '0);

    assert_byte_w1_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_op == 2'b10 |=> rsp_w1 == $past(req_m1));

    assert_bad_op_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_err == ($past(req_op) == 2'b11));

    assert_accept_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid && !req_ready);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
        $stable(rsp_w0) && $stable(rsp_w1) && $stable(rsp_err));

    assert_consume_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> !rsp_valid && req_ready);
endmodule

bind mem_align_unit mem_align_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_offset(req_offset), .req_m0(req_m0), .req_m1(req_m1),
    .req_val(req_val), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_err(rsp_err)
);

// File: tb/mem_align_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench for mem_align_unit: one task per scenario.
module mem_align_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'b00;
    logic [4:0]   req_offset = '0;
    logic [255:0] req_m0 = '0, req_m1 = '0, req_val = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic [255:0] rsp_data, rsp_w0, rsp_w1;
    logic         rsp_err;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [255:0] pa, pb, pv;

    always #2.5 clk = ~clk;

    mem_align_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_offset(req_offset), .req_m0(req_m0), .req_m1(req_m1),
        .req_val(req_val), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_err(rsp_err)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bget(input logic [255:0] w, input int k);
        return w[(31-k)*8 +: 8];
    endfunction

    function automatic logic [255:0] bset(input logic [255:0] w, input int k,
                                          input logic [7:0] b);
        logic [255:0] r = w;
        r[(31-k)*8 +: 8] = b;
        return r;
    endfunction

    // Issue one request, check the response, optionally stall, then consume.
    task automatic run_op(input logic [1:0] op, input int off, input logic [255:0] a0,
                          input logic [255:0] a1, input logic [255:0] v,
                          input string tag, input bit stall);
        logic [255:0] e_d = '0, e0 = a0, e1 = a1;
        logic e_err = 1'b0;
        case (op)
            2'b00: for (int i = 0; i < 32; i++)
                       e_d = bset(e_d, i, (off + i < 32) ? bget(a0, off + i)
                                                         : bget(a1, off + i - 32));
            2'b01: for (int i = 0; i < 32; i++)
                       if (off + i < 32) e0 = bset(e0, off + i, bget(v, i));
                       else              e1 = bset(e1, off + i - 32, bget(v, i));
            2'b10: e0 = bset(a0, off, v[7:0]);
            default: e_err = 1'b1;
        endcase
        @(negedge clk);
        chk(req_ready === 1'b1, "R10", {255'd0, req_ready}, 256'd1);
        req_valid = 1'b1; req_op = op; req_offset = 5'(off);
        req_m0 = a0; req_m1 = a1; req_val = v;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R9", {255'd0, rsp_valid}, 256'd1);
        chk(req_ready === 1'b0, "R9", {255'd0, req_ready}, 256'd0);
        chk(rsp_data === e_d, tag, rsp_data, e_d);
        chk(rsp_w0 === e0, tag, rsp_w0, e0);
        chk(rsp_w1 === e1, tag, rsp_w1, e1);
        chk(rsp_err === e_err, "R8", {255'd0, rsp_err}, {255'd0, e_err});
        if (stall) begin
            // R9: a request offered while busy must not disturb the response.
            req_valid = 1'b1; req_op = 2'b01; req_offset = 5'd3;
            req_m0 = ~a0; req_m1 = ~a1; req_val = ~v;
            @(negedge clk);
            req_valid = 1'b0;
            chk(rsp_valid === 1'b1, "R10", {255'd0, rsp_valid}, 256'd1);
            chk(rsp_data === e_d, "R9", rsp_data, e_d);
            chk(rsp_w0 === e0, "R9", rsp_w0, e0);
            chk(rsp_w1 === e1, "R10", rsp_w1, e1);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0, "R10", {255'd0, rsp_valid}, 256'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11", {255'd0, rsp_valid}, 256'd0);
        chk(req_ready === 1'b1, "R11", {255'd0, req_ready}, 256'd1);
        chk(rsp_data === '0 && rsp_w0 === '0 && rsp_w1 === '0 && rsp_err === 1'b0,
            "R11", rsp_data | rsp_w0 | rsp_w1, '0);
    endtask

    task automatic t_read();
        run_op(2'b00, 0, pa, pb, pv, "R3", 1'b0);
        run_op(2'b00, 5, pa, pb, pv, "R1", 1'b1);
        run_op(2'b00, 31, pa, pb, pv, "R1", 1'b0);
        // R2: read leaves the words untouched (checked inside run_op).
        run_op(2'b00, 17, pb, pa, pv, "R2", 1'b0);
    endtask

    task automatic t_write32();
        run_op(2'b01, 0, pa, pb, pv, "R5", 1'b0);
        run_op(2'b01, 13, pa, pb, pv, "R4", 1'b1);
        run_op(2'b01, 31, pa, pb, pv, "R6", 1'b0);
    endtask

    task automatic t_write8();
        logic [255:0] v = pv;
        v[7:0] = 8'hDF;
        run_op(2'b10, 1, pa, pb, v, "R7", 1'b0);
        run_op(2'b10, 0, pa, pb, v, "R7", 1'b0);
        run_op(2'b10, 31, pa, pb, v, "R7", 1'b1);
    endtask

    task automatic t_illegal();
        run_op(2'b11, 9, pa, pb, pv, "R8", 1'b1);
    endtask

    task automatic t_mixed();
        for (int n = 0; n < 24; n++) begin
            logic [255:0] a0, a1, v;
            for (int k = 0; k < 8; k++) begin
                a0[k*32 +: 32] = $urandom;
                a1[k*32 +: 32] = $urandom;
                v[k*32 +: 32]  = $urandom;
            end
            run_op(2'(n % 4), int'($urandom % 32), a0, a1, v,
                   (n % 4 == 0) ? "R1" : (n % 4 == 1) ? "R4" : (n % 4 == 2) ? "R7" : "R8",
                   n[0]);
        end
    endtask

    initial begin
        for (int k = 0; k < 32; k++) begin
            pa = bset(pa, k, 8'(8'h01 + k));
            pb = bset(pb, k, 8'(8'hA0 + k));
            pv = bset(pv, k, 8'(8'hC0 + k));
        end
        t_reset();
        t_read();
        t_write32();
        t_write8();
        t_illegal();
        t_mixed();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule